// File: doc/BRIEF.md
# Double-Buffered Peripheral DMA Channel

This block is a single peripheral DMA channel with two buffer slots, A and B. Each slot holds a start address and a remaining transfer count. The channel drains the active slot one unit at a time through a request/acknowledge memory port. When the active slot runs out, the channel switches to the other slot if software has armed it. Software can therefore refill one slot while the other is moving data.

Software reaches the channel through a small word-addressed register bus. The control/status word is never written directly. Software writes ones to a set address or to a clear address, and reads the word back at a third address. A device word selects the transfer direction and the unit width, among other settings. A level interrupt reports completion and error flags while the interrupt enable bit is set.

Top module: `dbuf_dma_chan`

## Requirements
- R1: After reset the status word reads 0x00, `irq_o` and `mem_req_o` are low, and slot A is the active slot.
- R2: The status word has these bits: bit0 run, bit1 irq enable, bit2 error, bit3 A done, bit4 A armed, bit5 B done, bit6 B armed, bit7 active slot (0 = A, 1 = B).
  - Writing offset 0x04 ORs bits 6:0 of the data into the status word.
  - Writing offset 0x08 clears every status bit whose data bit is 1.
  - Zero data bits and bit7 have no effect.
  - Offset 0x0C reads the status word. Offsets 0x04 and 0x08 read as zero.
- R3: `mem_req_o` is high while run and the active slot's armed bit are set and the active slot has no fault. On each cycle with both request and `mem_ack_i` high, the active slot's address rises by the unit size and its count falls by the unit size. `mem_addr_o` is the active slot's current address.
- R4: The edge on which the active slot's count reaches or passes zero sets that slot's done bit, clears its armed bit and leaves its count at 0.
- R5: On that same edge, the active slot moves to the other slot only if the other slot's armed bit was set before the edge. Otherwise it stays.
- R6: `irq_o` is high exactly when irq enable is set and at least one of error, A done or B done is set.
- R7: While run is clear, no unit moves and both slots keep their address and count. Setting run again resumes from where the transfer stopped.
- R8: If run and the active slot's armed bit are set and that slot's start address is not 4-byte aligned, or its count is 0, the next edge sets error and clears run.
- R9: The count registers (A at 0x14, B at 0x1C) keep the low 13 bits of the written data. A write to a start register (A at 0x10, B at 0x18) restarts that slot's address at the written value.
- R10: `mem_we_o` equals bit0 of the device word (1 = device to memory).
- R11: The device word at offset 0x00 reads back the full 32 bits written. Its bit3 selects the unit size: 0 gives 1 byte, 1 gives 2 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Write enable for the access |
| bus_addr_i | input | 5 | Byte offset within the channel |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from offset |
| mem_req_o | output | 1 | Unit transfer request |
| mem_ack_i | input | 1 | Unit transfer acknowledge |
| mem_addr_o | output | 32 | Memory address of the current unit |
| mem_we_o | output | 1 | 1 when memory is written |
| irq_o | output | 1 | Channel interrupt |

## Verification
Each register write takes effect on the clock edge at the end of its bus cycle. Read data, `mem_req_o`, `mem_addr_o` and `irq_o` are combinational from state, so they show the new value in the same cycle as that edge. Faults and completions are registered on the edge after the condition appears. They are visible one cycle later, together with the cleared run or armed bit.

The bench keeps a behavioural model that advances on every rising edge. It compares the model against every output a quarter period after each falling edge. By then the inputs driven at the falling edge have settled, and no state has yet moved.

// File: rtl/dbuf_dma_pkg.sv
package dbuf_dma_pkg;
  localparam logic [2:0] REG_DEV   = 3'd0;
  localparam logic [2:0] REG_SET   = 3'd1;
  localparam logic [2:0] REG_CLR   = 3'd2;
  localparam logic [2:0] REG_STAT  = 3'd3;
  localparam logic [2:0] REG_A_ADR = 3'd4;
  localparam logic [2:0] REG_A_CNT = 3'd5;

  localparam int unsigned ST_RUN    = 0;
  localparam int unsigned ST_IE     = 1;
  localparam int unsigned ST_ERR    = 2;
  localparam int unsigned ST_DONE_A = 3;
  localparam int unsigned ST_STRT_A = 4;
  localparam int unsigned ST_DONE_B = 5;
  localparam int unsigned ST_STRT_B = 6;
  localparam int unsigned ST_BIU    = 7;

  localparam int unsigned DEV_DIR  = 0;
  localparam int unsigned DEV_WIDE = 3;

  function automatic int unsigned strt_idx(logic slot);
    return slot ? ST_STRT_B : ST_STRT_A;
  endfunction

  function automatic int unsigned done_idx(logic slot);
    return slot ? ST_DONE_B : ST_DONE_A;
  endfunction
endpackage

// File: rtl/dbuf_dma_slot.sv
module dbuf_dma_slot #(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_base_i,
  input  logic          wr_cnt_i,
  input  logic [AW-1:0] wdata_i,
  input  logic          step_i,
  input  logic [1:0]    step_sz_i,
  output logic [AW-1:0] addr_o,
  output logic [CW-1:0] cnt_o,
  output logic          misaligned_o,
  output logic          empty_o,
  output logic          last_o
);
  logic [AW-1:0] base_q, off_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      off_q  <= '0;
    end else if (wr_base_i) begin
      base_q <= wdata_i;
      off_q  <= '0;
    end else if (step_i) begin
      off_q <= off_q + AW'(step_sz_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (wr_cnt_i) cnt_q <= wdata_i[CW-1:0];
    else if (step_i) cnt_q <= last_o ? '0 : cnt_q - CW'(step_sz_i);
  end

  assign addr_o       = base_q + off_q;
  assign cnt_o        = cnt_q;
  assign misaligned_o = |base_q[1:0];
  assign empty_o      = (cnt_q == '0);
  assign last_o       = (cnt_q <= CW'(step_sz_i));
endmodule

// File: rtl/dbuf_dma_ctl.sv
module dbuf_dma_ctl
  import dbuf_dma_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [6:0] sw_set_i,
  input  logic [6:0] sw_clr_i,
  input  logic       fault_i,
  input  logic       done_i,
  output logic [7:0] stat_o
);
  logic [7:0] stat_q, stat_d;
  logic       act;

  assign act = stat_q[ST_BIU];

  always_comb begin
    stat_d = stat_q;
    if (fault_i) begin
      stat_d[ST_ERR] = 1'b1;
      stat_d[ST_RUN] = 1'b0;
    end
    if (done_i) begin
      stat_d[done_idx(act)] = 1'b1;
      stat_d[strt_idx(act)] = 1'b0;
      if (stat_q[strt_idx(!act)]) stat_d[ST_BIU] = !act;
    end
    // software last: set then clear, active-slot bit is hardware-owned
    stat_d[6:0] = (stat_d[6:0] | sw_set_i) & ~sw_clr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else stat_q <= stat_d;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/dbuf_dma_chan.sv
module dbuf_dma_chan
  import dbuf_dma_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned CW    = 13,
  parameter int unsigned OFS_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_sel_i,
  input  logic             bus_we_i,
  input  logic [OFS_W-1:0] bus_addr_i,
  input  logic [31:0]      bus_wdata_i,
  output logic [31:0]      bus_rdata_o,
  output logic             mem_req_o,
  input  logic             mem_ack_i,
  output logic [AW-1:0]    mem_addr_o,
  output logic             mem_we_o,
  output logic             irq_o
);
  localparam int unsigned NSLOT = 2;

  logic [2:0]    reg_idx;
  logic          acc, wr_en;
  logic [31:0]   dev_q;
  logic [7:0]    stat;
  logic [1:0]    step_sz;
  logic          act, strt_act, fault, step, done_ev;
  logic [CW-1:0] act_cnt;

  logic [AW-1:0] slot_addr  [NSLOT];
  logic [CW-1:0] slot_cnt   [NSLOT];
  logic          slot_mis   [NSLOT];
  logic          slot_empty [NSLOT];
  logic          slot_last  [NSLOT];

  assign reg_idx = bus_addr_i[4:2];
  assign acc     = bus_sel_i && (bus_addr_i[1:0] == 2'b00);
  assign wr_en   = acc && bus_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dev_q <= '0;
    else if (wr_en && reg_idx == REG_DEV) dev_q <= bus_wdata_i;
  end

  assign step_sz  = dev_q[DEV_WIDE] ? 2'd2 : 2'd1;
  assign act      = stat[ST_BIU];
  assign strt_act = stat[strt_idx(act)];
  assign act_cnt  = slot_cnt[act];
  assign fault    = stat[ST_RUN] && strt_act && (slot_mis[act] || slot_empty[act]);
  assign mem_req_o = stat[ST_RUN] && strt_act && !slot_mis[act] && !slot_empty[act];
  assign step     = mem_req_o && mem_ack_i;
  assign done_ev  = step && slot_last[act];

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    localparam logic [2:0] ADR_IDX = REG_A_ADR + 3'(2 * i);
    localparam logic [2:0] CNT_IDX = REG_A_CNT + 3'(2 * i);
    dbuf_dma_slot #(.AW(AW), .CW(CW)) u_slot (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_base_i   (wr_en && reg_idx == ADR_IDX),
      .wr_cnt_i    (wr_en && reg_idx == CNT_IDX),
      .wdata_i     (bus_wdata_i[AW-1:0]),
      .step_i      (step && (act == 1'(i))),
      .step_sz_i   (step_sz),
      .addr_o      (slot_addr[i]),
      .cnt_o       (slot_cnt[i]),
      .misaligned_o(slot_mis[i]),
      .empty_o     (slot_empty[i]),
      .last_o      (slot_last[i])
    );
  end

  dbuf_dma_ctl u_ctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sw_set_i((wr_en && reg_idx == REG_SET) ? bus_wdata_i[6:0] : 7'd0),
    .sw_clr_i((wr_en && reg_idx == REG_CLR) ? bus_wdata_i[6:0] : 7'd0),
    .fault_i (fault),
    .done_i  (done_ev),
    .stat_o  (stat)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (acc) begin
      case (reg_idx)
        REG_DEV:   bus_rdata_o = dev_q;
        REG_STAT:  bus_rdata_o = 32'(stat);
        3'd4:      bus_rdata_o = 32'(slot_addr[0]);
        3'd5:      bus_rdata_o = 32'(slot_cnt[0]);
        3'd6:      bus_rdata_o = 32'(slot_addr[1]);
        3'd7:      bus_rdata_o = 32'(slot_cnt[1]);
        default:   bus_rdata_o = '0;
      endcase
    end
  end

  assign mem_addr_o = slot_addr[act];
  assign mem_we_o   = dev_q[DEV_DIR];
  assign irq_o      = stat[ST_IE] && (stat[ST_ERR] || stat[ST_DONE_A] || stat[ST_DONE_B]);
endmodule

// File: rtl/dbuf_dma_chan_chk.sv
module dbuf_dma_chan_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 13
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bus_sel_i,
  input logic          mem_req_i,
  input logic          mem_ack_i,
  input logic [AW-1:0] mem_addr_i,
  input logic          irq_i,
  input logic [7:0]    stat_i,
  input logic [CW-1:0] act_cnt_i,
  input logic [1:0]    step_sz_i
);
  logic strt_act;
  assign strt_act = stat_i[7] ? stat_i[6] : stat_i[4];

  a_r3_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_i && mem_ack_i && act_cnt_i > CW'(step_sz_i) && !bus_sel_i)
    |=> mem_addr_i == $past(mem_addr_i) + AW'($past(step_sz_i)));

  a_r4_done_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_i && mem_ack_i && act_cnt_i <= CW'(step_sz_i) && !bus_sel_i)
    |=> ($past(stat_i[7]) ? stat_i[5] : stat_i[3]));

  a_r6_irq_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(stat_i[3]) && stat_i[1]) |-> irq_i);

  a_r7_pause_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_i[0] |-> !mem_req_i);

  a_r7_pause_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stat_i[0] && !bus_sel_i) |=> $stable(mem_addr_i));

  a_r8_zero_count_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_i[0] && strt_act && act_cnt_i == '0 && !bus_sel_i) |=> (stat_i[2] && !stat_i[0]));
endmodule

bind dbuf_dma_chan dbuf_dma_chan_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bus_sel_i (bus_sel_i),
  .mem_req_i (mem_req_o),
  .mem_ack_i (mem_ack_i),
  .mem_addr_i(mem_addr_o),
  .irq_i     (irq_o),
  .stat_i    (stat),
  .act_cnt_i (act_cnt),
  .step_sz_i (step_sz)
);

// File: tb/dbuf_dma_chan_bench.sv
module dbuf_dma_chan_bench;
  localparam int CLK_P = 10;

  logic        clk = 0, rst_n = 0;
  logic        sel = 0, we = 0, ack = 1, ack_alt = 0;
  logic [4:0]  addr = 0;
  logic [31:0] wdata = 0, rdata, maddr;
  logic        req, mwe, irq;
  int          checks = 0, errors = 0, cycles = 0;

  // behavioural model state
  logic [7:0]  m_st = 0;
  logic [31:0] m_dev = 0;
  logic [31:0] m_base [2] = '{0, 0};
  logic [31:0] m_off  [2] = '{0, 0};
  int          m_cnt  [2] = '{0, 0};

  dbuf_dma_chan u_dbuf_dma_chan (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .mem_req_o(req), .mem_ack_i(ack),
    .mem_addr_o(maddr), .mem_we_o(mwe), .irq_o(irq));

  always #(CLK_P/2) clk = ~clk;

  function automatic int sz();
    return m_dev[3] ? 2 : 1;
  endfunction
  function automatic bit m_act();
    return m_st[7];
  endfunction
  function automatic bit m_armed();
    return m_act() ? m_st[6] : m_st[4];
  endfunction
  function automatic bit m_bad();
    return (m_base[m_act()][1:0] != 0) || (m_cnt[m_act()] == 0);
  endfunction
  function automatic bit m_req();
    return m_st[0] && m_armed() && !m_bad();
  endfunction
  function automatic logic [31:0] m_rd(logic [4:0] a);
    if (a[1:0] != 0) return 0;
    case (a[4:2])
      0: return m_dev;
      3: return {24'd0, m_st};
      4: return m_base[0] + m_off[0];
      5: return m_cnt[0];
      6: return m_base[1] + m_off[1];
      7: return m_cnt[1];
      default: return 0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // model advances on each rising edge
  always @(posedge clk) if (rst_n) begin
    automatic logic [7:0] nst = m_st;
    automatic bit a = m_act();
    automatic bit rq = m_req();
    automatic int s = sz();
    if (m_st[0] && m_armed() && m_bad()) begin nst[2] = 1; nst[0] = 0; end
    if (rq && ack) begin
      m_off[a] = m_off[a] + s;
      if (m_cnt[a] <= s) begin
        m_cnt[a] = 0;
        nst[a ? 5 : 3] = 1;
        nst[a ? 6 : 4] = 0;
        if (a ? m_st[4] : m_st[6]) nst[7] = !a;
      end else m_cnt[a] = m_cnt[a] - s;
    end
    if (sel && we && addr[1:0] == 0) begin
      case (addr[4:2])
        0: m_dev = wdata;
        1: nst[6:0] = nst[6:0] | wdata[6:0];
        2: nst[6:0] = nst[6:0] & ~wdata[6:0];
        4: begin m_base[0] = wdata; m_off[0] = 0; end
        5: m_cnt[0] = wdata[12:0];
        6: begin m_base[1] = wdata; m_off[1] = 0; end
        7: m_cnt[1] = wdata[12:0];
        default: ;
      endcase
    end
    m_st = nst;
  end

  // per-cycle comparison, a quarter period after the falling edge
  always begin
    @(negedge clk);
    #(CLK_P/4);
    if (rst_n) begin
      chk("R3 req", {31'd0, req}, {31'd0, m_req()});
      chk("R3 addr", maddr, m_base[m_act()] + m_off[m_act()]);
      chk("R10 we", {31'd0, mwe}, {31'd0, m_dev[0]});
      chk("R6 irq", {31'd0, irq}, {31'd0, m_st[1] && (m_st[2] || m_st[3] || m_st[5])});
      chk("R2 rdata", rdata, sel ? m_rd(addr) : 32'd0);
    end
  end

  always @(negedge clk) ack <= ack_alt ? ~ack : 1'b1;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles expected below 20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr(logic [2:0] idx, logic [31:0] d);
    @(negedge clk);
    sel = 1; we = 1; addr = {idx, 2'b00}; wdata = d;
    @(negedge clk);
    sel = 0; we = 0;
  endtask

  task automatic rd(string tag, logic [2:0] idx, logic [31:0] mask, logic [31:0] exp);
    @(negedge clk);
    sel = 1; we = 0; addr = {idx, 2'b00};
    #(CLK_P/4 + 1);
    chk(tag, rdata & mask, exp);
    @(negedge clk);
    sel = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #(CLK_P/4 + 1);
    chk("R1 irq in reset", {31'd0, irq}, 0);
    chk("R1 req in reset", {31'd0, req}, 0);
    rst_n = 1;
    rd("R1 status after reset", 3'd3, 32'hFF, 32'h00);
    // R2: active-slot bit ignores set; set/clr offsets read zero
    wr(3'd1, 32'h80);
    rd("R2 bit7 not settable", 3'd3, 32'h80, 32'h00);
    rd("R2 set offset reads 0", 3'd1, 32'hFFFF_FFFF, 0);
    // R11 device word
    wr(3'd0, 32'hA5A5_0A51);
    rd("R11 device readback", 3'd0, 32'hFFFF_FFFF, 32'hA5A5_0A51);
    // R4/R5 ping-pong A -> B with byte units
    wr(3'd4, 32'h1000); wr(3'd5, 5);
    wr(3'd6, 32'h2000); wr(3'd7, 3);
    wr(3'd1, 32'h53);
    idle(20);
    rd("R4 R5 status after both slots", 3'd3, 32'hFF, 32'hAB);
    rd("R4 A count", 3'd5, 32'hFFFF_FFFF, 0);
    rd("R3 A address", 3'd4, 32'hFFFF_FFFF, 32'h1005);
    chk("R6 irq on done", {31'd0, irq}, 1);
    wr(3'd2, 32'h28);
    #(CLK_P/4 + 1);
    chk("R6 irq after clear", {31'd0, irq}, 0);
    // R7 pause with 16-bit units and alternating ack, slot B stays active
    wr(3'd0, 32'h9);
    ack_alt = 1;
    wr(3'd6, 32'h3000); wr(3'd7, 7);
    wr(3'd1, 32'h40);
    idle(2);
    wr(3'd2, 32'h01);
    idle(4);
    #(CLK_P/4 + 1);
    chk("R7 no request while paused", {31'd0, req}, 0);
    wr(3'd1, 32'h01);
    idle(20);
    rd("R7 B count drained", 3'd7, 32'hFFFF_FFFF, 0);
    rd("R7 B address", 3'd6, 32'hFFFF_FFFF, 32'h3008);
    rd("R5 B done, active stays B", 3'd3, 32'hE0, 32'hA0);
    // R8 unaligned start and zero count
    wr(3'd2, 32'h7F);
    wr(3'd6, 32'h4002); wr(3'd7, 4);
    wr(3'd1, 32'h41);
    idle(3);
    rd("R8 unaligned sets error", 3'd3, 32'h05, 32'h04);
    wr(3'd6, 32'h4000); wr(3'd7, 0);
    wr(3'd2, 32'h04);
    wr(3'd1, 32'h01);
    idle(3);
    rd("R8 zero count sets error", 3'd3, 32'h05, 32'h04);
    // R9 count mask
    wr(3'd5, 32'hFFFF_FFFF);
    rd("R9 count masked", 3'd5, 32'hFFFF_FFFF, 32'h1FFF);
    wr(3'd2, 32'h80);
    rd("R2 bit7 not clearable", 3'd3, 32'h80, 32'h80);
    idle(4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule